// File: doc/BRIEF.md
# Multi-Channel Hit Event Builder

This block gathers timing records from eight time-to-digital converter channels and turns them into one stream of 64-bit frame words for a downstream line encoder. Each record holds an arrival-time stamp and a pulse-width value. Storage has two tiers:

- Every channel writes into a small private queue of its own.
- A rotating arbiter moves at most one record per cycle from those queues into one shared queue.
- On the way to the shared queue, each record is tagged with the number of the channel it came from.

A framer drains the shared queue into frames. Each frame has three parts: a header carrying a frame number and the per-channel drop counts, up to sixteen tagged data words, and a closing trailer. When there is nothing to send, the framer emits an all-zero fill word. The output presents a word on every cycle, and the receiver takes it by raising its ready signal. At the intended rate of 160 million words per second, the framer emits one word per accepted cycle.

Top module: `hit_event_builder`

## Requirements
- R1: After reset the output offers the fill word (all 64 bits zero) with the valid flag high.
- R2: While the shared queue is empty and no frame is open, the output is the fill word: kind bits [63:62] = 00 and every other bit zero.
- R3: A frame opens with a header word: kind 01, frame number in [61:46], and the drop count of channel c in bits [4c+3:4c]. Frame numbers begin at 0 after reset and rise by one per completed frame. A header is offered only when the shared queue holds a record, and the word accepted right after a header is a data word.
- R4: A data word has kind 10, the source channel number in [61:59], the arrival stamp (24 bits) in [39:16] and the width value (16 bits) in [15:0]. Records of one channel leave in the order in which they arrived.
- R5: A frame carries at most 16 data words. The trailer has kind 11, the frame number in [61:46], and the number of data words in the frame in [4:0].
- R6: A frame closes with its trailer as soon as the shared queue is empty, even when it holds fewer than 16 words. After a trailer is accepted, the next word is a header or the fill word.
- R7: A hit that arrives while its channel's private queue (8 entries) is full is discarded. That channel's 4-bit drop count then rises by one and saturates at 15. The next accepted header reports the count, and accepting the header clears it.
- R8: While ready is low, an offered data word is held unchanged and nothing is consumed.
- R9: The arbiter grants at most one channel per cycle and rotates priority to the channel after the last one granted. After reset, channel 0 has top priority. When all channels hold a record at once, the first data words come out in channel order 0 to 7. The shared queue holds 32 records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitValid | input | 8 | One strobe per channel: a record is present this cycle |
| hitToa | input | 192 | Arrival stamps, 24 bits per channel, channel c at [24c+23:24c] |
| hitTot | input | 128 | Width values, 16 bits per channel, channel c at [16c+15:16c] |
| outWord | output | 64 | Frame word offered to the encoder |
| outValid | output | 1 | Word present (high whenever out of reset) |
| outReady | input | 1 | Receiver takes the word on this cycle |

## Verification
The bench stalls the receiver while a single channel floods. With this stall, the combined capacity of 40 records is used up, and the drop count must show exactly 5. A second run must show the count stopping at 15. A design that counted a hit which had in fact been stored, or that let the count wrap, would report the wrong nibble in the next header. Simultaneous hits on all eight channels check the rotation start: a priority that began anywhere but channel 0, or that did not advance, would reorder the data words. A single lone hit must produce a frame of one word, and a long backlog must be cut at 16 words. Pulling ready low in the middle of a frame exposes any design that pops or changes the word while stalled.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic [1:0] {
    SEL_FILL = 2'b00,
    SEL_HDR  = 2'b01,
    SEL_DATA = 2'b10,
    SEL_TRL  = 2'b11
  } wordSel_e;

  typedef struct packed {
    wordSel_e sel;
    logic     l2Pop;
    logic     hdrTake;
  } ctrl_t;
endpackage

// File: rtl/eb_fifo.sv
module eb_fifo #(
  parameter int W     = 40,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dout  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/eb_control.sv
module eb_control
  import eb_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int MAX_WORDS = 16,
  parameter int FCNT_W    = 16,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int DCNT_W   = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] l1Empty,
  input  logic              l2Empty,
  input  logic              l2Full,
  input  logic              outReady,
  output logic [NUM_CH-1:0] grant,
  output ctrl_t             ctrl,
  output logic [FCNT_W-1:0] frameCnt,
  output logic [DCNT_W-1:0] dataCnt
);
  typedef enum logic {FR_IDLE, FR_DATA} frState_e;

  frState_e      state;
  logic [CH_W-1:0] rrPtr, grantIdx, probe;

  // rotating search from rrPtr; NUM_CH must be a power of two
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    probe    = '0;
    if (!l2Full) begin
      for (int i = 0; i < NUM_CH; i++) begin
        probe = rrPtr + CH_W'(i);
        if (!l1Empty[probe] && grant == '0) begin
          grant[probe] = 1'b1;
          grantIdx     = probe;
        end
      end
    end
  end

  always_comb begin
    ctrl.sel = SEL_FILL;
    if (state == FR_IDLE) ctrl.sel = l2Empty ? SEL_FILL : SEL_HDR;
    else ctrl.sel = (l2Empty || dataCnt == DCNT_W'(MAX_WORDS)) ? SEL_TRL : SEL_DATA;
    ctrl.l2Pop   = (ctrl.sel == SEL_DATA) && outReady;
    ctrl.hdrTake = (ctrl.sel == SEL_HDR) && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr    <= '0;
      state    <= FR_IDLE;
      frameCnt <= '0;
      dataCnt  <= '0;
    end else begin
      if (grant != '0) rrPtr <= grantIdx + 1'b1;
      if (outReady) begin
        case (ctrl.sel)
          SEL_HDR: begin
            state   <= FR_DATA;
            dataCnt <= '0;
          end
          SEL_DATA: dataCnt <= dataCnt + 1'b1;
          SEL_TRL: begin
            state    <= FR_IDLE;
            frameCnt <= frameCnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eb_datapath.sv
module eb_datapath
  import eb_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int TOA_W     = 24,
  parameter int TOT_W     = 16,
  parameter int L1_DEPTH  = 8,
  parameter int L2_DEPTH  = 32,
  parameter int OVF_W     = 4,
  parameter int FCNT_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int WORD_W    = 64,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int DCNT_W   = $clog2(MAX_WORDS + 1),
  localparam int L1_W     = TOA_W + TOT_W,
  localparam int L2_W     = CH_W + L1_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        hitValid,
  input  logic [NUM_CH*TOA_W-1:0]  hitToa,
  input  logic [NUM_CH*TOT_W-1:0]  hitTot,
  input  logic [NUM_CH-1:0]        grant,
  input  ctrl_t                    ctrl,
  input  logic [FCNT_W-1:0]        frameCnt,
  input  logic [DCNT_W-1:0]        dataCnt,
  output logic [NUM_CH-1:0]        l1Empty,
  output logic                     l2Empty,
  output logic                     l2Full,
  output logic [WORD_W-1:0]        outWord
);
  logic [L1_W-1:0]          l1Head [NUM_CH];
  logic [NUM_CH-1:0]        l1Full;
  logic [NUM_CH*OVF_W-1:0]  ovfFlat;
  logic [L2_W-1:0]          moveRec, l2Head;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic drop;
    logic [OVF_W-1:0] ovfCnt;
    assign drop = hitValid[c] && l1Full[c];

    eb_fifo #(.W(L1_W), .DEPTH(L1_DEPTH)) u_l1 (
      .clk  (clk),
      .rstN (rstN),
      .push (hitValid[c]),
      .din  ({hitToa[c*TOA_W +: TOA_W], hitTot[c*TOT_W +: TOT_W]}),
      .pop  (grant[c]),
      .dout (l1Head[c]),
      .empty(l1Empty[c]),
      .full (l1Full[c])
    );

    always_ff @(posedge clk) begin
      if (!rstN) ovfCnt <= '0;
      else if (ctrl.hdrTake) ovfCnt <= drop ? OVF_W'(1) : '0;
      else if (drop && ovfCnt != '1) ovfCnt <= ovfCnt + 1'b1;
    end
    assign ovfFlat[c*OVF_W +: OVF_W] = ovfCnt;
  end

  always_comb begin
    moveRec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) moveRec = {CH_W'(c), l1Head[c]};
    end
  end

  eb_fifo #(.W(L2_W), .DEPTH(L2_DEPTH)) u_l2 (
    .clk  (clk),
    .rstN (rstN),
    .push (grant != '0),
    .din  (moveRec),
    .pop  (ctrl.l2Pop),
    .dout (l2Head),
    .empty(l2Empty),
    .full (l2Full)
  );

  always_comb begin
    outWord = '0;
    outWord[WORD_W-1 -: 2] = ctrl.sel;
    case (ctrl.sel)
      SEL_HDR: begin
        outWord[WORD_W-3 -: FCNT_W]     = frameCnt;
        outWord[NUM_CH*OVF_W-1:0]       = ovfFlat;
      end
      SEL_DATA: begin
        outWord[WORD_W-3 -: CH_W]       = l2Head[L2_W-1 -: CH_W];
        outWord[L1_W-1:0]               = l2Head[L1_W-1:0];
      end
      SEL_TRL: begin
        outWord[WORD_W-3 -: FCNT_W]     = frameCnt;
        outWord[DCNT_W-1:0]             = dataCnt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hit_event_builder.sv
module hit_event_builder
  import eb_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int TOA_W     = 24,
  parameter int TOT_W     = 16,
  parameter int L1_DEPTH  = 8,
  parameter int L2_DEPTH  = 32,
  parameter int OVF_W     = 4,
  parameter int FCNT_W    = 16,
  parameter int MAX_WORDS = 16,
  parameter int WORD_W    = 64,
  localparam int DCNT_W   = $clog2(MAX_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       hitValid,
  input  logic [NUM_CH*TOA_W-1:0] hitToa,
  input  logic [NUM_CH*TOT_W-1:0] hitTot,
  output logic [WORD_W-1:0]       outWord,
  output logic                    outValid,
  input  logic                    outReady
);
  ctrl_t             ctrl;
  logic [NUM_CH-1:0] grant, l1Empty;
  logic              l2Empty, l2Full;
  logic [FCNT_W-1:0] frameCnt;
  logic [DCNT_W-1:0] dataCnt;

  assign outValid = rstN;

  eb_control #(.NUM_CH(NUM_CH), .MAX_WORDS(MAX_WORDS), .FCNT_W(FCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .l1Empty(l1Empty), .l2Empty(l2Empty), .l2Full(l2Full),
    .outReady(outReady), .grant(grant), .ctrl(ctrl), .frameCnt(frameCnt), .dataCnt(dataCnt)
  );

  eb_datapath #(
    .NUM_CH(NUM_CH), .TOA_W(TOA_W), .TOT_W(TOT_W), .L1_DEPTH(L1_DEPTH), .L2_DEPTH(L2_DEPTH),
    .OVF_W(OVF_W), .FCNT_W(FCNT_W), .MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitToa(hitToa), .hitTot(hitTot),
    .grant(grant), .ctrl(ctrl), .frameCnt(frameCnt), .dataCnt(dataCnt),
    .l1Empty(l1Empty), .l2Empty(l2Empty), .l2Full(l2Full), .outWord(outWord)
  );
endmodule

// File: rtl/hit_event_builder_chk.sv
module hit_event_builder_chk #(
  parameter int NUM_CH    = 8,
  parameter int MAX_WORDS = 16,
  parameter int WORD_W    = 64,
  localparam int DCNT_W   = $clog2(MAX_WORDS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] outWord,
  input logic              outValid,
  input logic              outReady,
  input logic [NUM_CH-1:0] grant
);
  logic [1:0] kind;
  assign kind = outWord[WORD_W-1 -: 2];

  AST_FILL_ALL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (kind == 2'b00) |-> (outWord == '0)); // R2
  AST_HDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && kind == 2'b01) |=> (kind == 2'b10)); // R3
  AST_TRL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (kind == 2'b11) |-> (outWord[DCNT_W-1:0] <= DCNT_W'(MAX_WORDS))); // R5
  AST_AFTER_TRL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && kind == 2'b11) |=> (kind == 2'b00 || kind == 2'b01)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && kind == 2'b10) |=> $stable(outWord)); // R8
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R9
endmodule

bind hit_event_builder hit_event_builder_chk #(
  .NUM_CH(NUM_CH), .MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .outWord(outWord), .outValid(outValid),
  .outReady(outReady), .grant(grant)
);

// File: tb/hit_event_builder_bench.sv
module hit_event_builder_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   hitValid = '0;
  logic [191:0] hitToa = '0;
  logic [127:0] hitTot = '0;
  logic [63:0]  outWord;
  logic         outValid;
  logic         outReady = 1'b0;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  logic [42:0] expQ[$];
  int          chanLog[$];
  int          trlLog[$];
  logic [31:0] pendOvf = '0;
  logic [15:0] expFrame = '0;
  bit          inFrame = 0;
  int          nData = 0;

  always #10 clk = ~clk;

  hit_event_builder u_hit_event_builder (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitToa(hitToa), .hitTot(hitTot),
    .outWord(outWord), .outValid(outValid), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: a word is accepted at the next posedge when ready is high here
  always @(negedge clk) begin
    if (rstN && outReady) begin
      case (outWord[63:62])
        2'b00: if (inFrame) check(0, "R6 fill inside open frame", outWord, 0);
        2'b01: begin
          check(!inFrame, "R3 header inside open frame", outWord, 0);
          check(outWord[61:46] == expFrame, "R3 header frame number", outWord[61:46], expFrame);
          check(outWord[31:0] == pendOvf, "R7 drop counts in header", outWord[31:0], pendOvf);
          pendOvf = '0;
          inFrame = 1;
          nData = 0;
        end
        2'b10: begin
          int ch;
          int hit;
          ch = int'(outWord[61:59]);
          hit = -1;
          check(inFrame, "R4 data outside frame", outWord, 0);
          for (int i = 0; i < expQ.size(); i++) if (hit < 0 && int'(expQ[i][42:40]) == ch) hit = i;
          if (hit < 0) check(0, "R4 unexpected data word", outWord, 0);
          else begin
            check(expQ[hit] == {outWord[61:59], outWord[39:0]}, "R4 data word content",
                  {21'd0, outWord[61:59], outWord[39:0]}, {21'd0, expQ[hit]});
            expQ.delete(hit);
          end
          chanLog.push_back(ch);
          nData++;
          if (nData > 16) check(0, "R5 more than 16 data words", nData, 16);
        end
        default: begin
          check(int'(outWord[4:0]) == nData, "R5 trailer word count", outWord[4:0], nData);
          check(outWord[61:46] == expFrame, "R5 trailer frame number", outWord[61:46], expFrame);
          trlLog.push_back(int'(outWord[4:0]));
          expFrame++;
          inFrame = 0;
        end
      endcase
    end
  end

  task automatic hit(input int ch, input logic [23:0] toa, input logic [15:0] tot, input bit stored);
    @(posedge clk); #2;
    hitValid = '0;
    hitValid[ch] = 1'b1;
    hitToa[ch*24 +: 24] = toa;
    hitTot[ch*16 +: 16] = tot;
    if (stored) expQ.push_back({3'(ch), toa, tot});
    @(posedge clk); #2;
    hitValid = '0;
  endtask

  task automatic drain();
    int guard = 0;
    @(posedge clk); #2; outReady = 1'b1;
    while ((expQ.size() != 0 || inFrame) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !inFrame, "R4 all stored records delivered", expQ.size(), 0);
    check(outWord == '0, "R2 fill word once drained", outWord, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b1 && outWord == '0, "R1 reset state", outWord, 0);
    repeat (3) @(negedge clk);
    check(outWord == '0, "R2 fill word with nothing stored", outWord, 0);

    // all channels at once: order must start at channel 0 (R9)
    @(posedge clk); #2;
    outReady = 1'b1;
    chanLog.delete();
    hitValid = 8'hFF;
    for (int c = 0; c < 8; c++) begin
      hitToa[c*24 +: 24] = 24'h100 + 24'(c);
      hitTot[c*16 +: 16] = 16'h50 + 16'(c);
      expQ.push_back({3'(c), 24'h100 + 24'(c), 16'h50 + 16'(c)});
    end
    @(posedge clk); #2; hitValid = '0;
    drain();
    check(chanLog.size() == 8, "R9 eight words in burst", chanLog.size(), 8);
    for (int i = 0; i < 8 && i < chanLog.size(); i++)
      check(chanLog[i] == i, "R9 rotation order from channel 0", chanLog[i], i);
    check(trlLog.size() == 1 && trlLog[0] == 8, "R6 short frame closes on empty", trlLog.size(), 1);

    // lone hit: frame of one word
    trlLog.delete();
    hit(5, 24'hABCDEF, 16'h1234, 1);
    drain();
    check(trlLog.size() == 1 && trlLog[0] == 1, "R6 single-word frame", trlLog.size() ? trlLog[0] : -1, 1);

    // flood channel 2 while stalled: 40 stored, 5 dropped
    @(posedge clk); #2; outReady = 1'b0;
    trlLog.delete();
    for (int i = 0; i < 45; i++) hit(2, 24'h2000 + 24'(i), 16'(i * 3), i < 40);
    pendOvf = 32'h0000_0500;
    @(posedge clk); #2; outReady = 1'b1;
    repeat (3) @(posedge clk);
    #2 outReady = 1'b0;
    begin
      logic [63:0] held;
      @(negedge clk); held = outWord;
      check(held[63:62] == 2'b10, "R8 stalled on a data word", held[63:62], 2);
      repeat (3) @(negedge clk);
      check(outWord == held, "R8 word held while stalled", outWord, held);
    end
    drain();
    check(trlLog.size() >= 1 && trlLog[0] == 16, "R5 frame cut at 16 words",
          trlLog.size() ? trlLog[0] : -1, 16);
    check(pendOvf == '0, "R7 drop count reported", pendOvf, 0);

    // saturating drop count on channel 7
    @(posedge clk); #2; outReady = 1'b0;
    for (int i = 0; i < 60; i++) hit(7, 24'h7000 + 24'(i * 5), 16'hF000 + 16'(i), i < 40);
    pendOvf = 32'hF000_0000;
    drain();
    check(pendOvf == '0, "R7 saturated count reported", pendOvf, 0);

    // a later frame reports cleared counts
    hit(3, 24'h33, 16'h3, 1);
    drain();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule